// File: doc/BRIEF.md
# Controller Reset and Power-Up Sequencer

This block brings a serial-link controller and its PHY out of reset in a fixed order. One `start` pulse begins the sequence. The block turns on the supply and then three clocks, one per cycle: PHY clock, bus clock and core clock. It then lifts the PHY power-down. After a settling delay it enables the reference clock, so that the PHY's internally synchronised reset stays asserted long enough. It then waits for the clocks to settle and pulses the external endpoint reset for a long fixed time. Last, it releases the PHY reset and polls a PLL lock flag until the flag is set or the allowed number of polls runs out.

Each enable step has a failure input. If a step fails, the block turns off what it has already enabled, one item per cycle and newest first, so the supply is the last to go, and then raises `seq_err`. A `pwr_down` request at any time returns every output to its rest state within one cycle. All waits are cycle counts set by parameters, so a testbench can use short values. The active level of the external reset comes from the `rst_act_high` input.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, `supply_en`, `clk_en` and `ref_clk_en` are 0 and `phy_pd` and `phy_rst` are 1. `seq_done` and `seq_err` are 0. `ep_rst` sits at its inactive level, which is the inverse of `rst_act_high`.
- R2: A `start` pulse sampled in idle sets `supply_en` one cycle later. It then sets `clk_en[0]` (PHY), `clk_en[1]` (bus) and `clk_en[2]` (core) on the three following cycles, one per cycle.
- R3: `phy_pd` falls one cycle after the core clock enable rises. `ref_clk_en` rises exactly REF_DLY cycles after `phy_pd` falls.
- R4: `ep_rst` moves to its active level (equal to `rst_act_high`) exactly SETTLE_DLY cycles after `ref_clk_en` rises.
- R5: `ep_rst` stays active for exactly PERST_DLY cycles. It then returns to its inactive level, and `phy_rst` falls in the same cycle.
- R6: `pll_locked` is sampled every POLL_GAP cycles, with the first sample POLL_GAP cycles after `phy_rst` falls. `seq_done` rises on the cycle after the first sample that sees the flag set.
- R7: If POLL_MAX samples all see the flag clear, `seq_err` rises POLL_GAP×POLL_MAX cycles after `phy_rst` falls. Supply, clocks and reference clock stay enabled.
- R8: Bit k of `step_fail` (0 supply, 1 PHY clock, 2 bus clock, 3 core clock) is read while step k is the newest enable. If it is high, step k's enable drops two cycles after it rose. The earlier enables then drop one per cycle in reverse order, supply last, and `seq_err` rises together with the supply drop.
- R9: `pwr_down` from any state returns every output to its R1 value one cycle later. This includes turning off the supply, setting `phy_pd` and dropping `ref_clk_en`.
- R10: `start` has no effect while a sequence is running or after it has completed. The outputs keep their timing and their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the power-up sequence (idle or failed only) |
| pwr_down | input | 1 | Return every output to its rest state |
| rst_act_high | input | 1 | 1: external reset is active high; 0: active low |
| step_fail | input | 4 | Per-step enable failure: supply, PHY clk, bus clk, core clk |
| pll_locked | input | 1 | PHY PLL lock flag |
| supply_en | output | 1 | Supply enable |
| clk_en | output | 3 | Clock enables: [0] PHY, [1] bus, [2] core |
| phy_pd | output | 1 | PHY power-down (1 = powered down) |
| ref_clk_en | output | 1 | Reference clock enable |
| ep_rst | output | 1 | External endpoint reset, level set by `rst_act_high` |
| phy_rst | output | 1 | PHY reset (1 = held in reset) |
| seq_done | output | 1 | Sequence finished with PLL locked |
| seq_err | output | 1 | Step failure or lock timeout |

## Verification
The main sequence is run three times. The first run uses an active-high external reset and a lock flag that is already set, which shows the first-sample timing. The second uses an active-low reset and a flag that sets late, so the wait can only be correct if polling continues at the gap spacing. The third never locks, which separates a lock timeout, where the enables stay on, from a step failure. Failures injected at the supply, bus clock and core clock steps check that the unwind length and order follow the failing step. Power-down is applied mid-wait, after completion and after failure. Stray `start` pulses are applied during the external reset pulse and after completion, and must leave the timing unchanged.

// File: rtl/pwrup_pkg.sv
`timescale 1ns/1ps
package pwrup_pkg;

    // Enable steps, in the order they are switched on.
    localparam int unsigned NUM_EN    = 4;
    localparam int unsigned EN_SUPPLY = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_UNWIND,
        ST_PWRUP,
        ST_SETTLE,
        ST_EPRST,
        ST_LOCK,
        ST_DONE,
        ST_FAILED
    } seq_state_e;

endpackage

// File: rtl/pwrup_timer.sv
`timescale 1ns/1ps
// Loadable down-counter. After a load of N, expire is high during the
// N-th cycle, so a state that loads it on entry lasts exactly N cycles.
module pwrup_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == W'(1));

    // R3..R6: every timed wait relies on a steady one-per-cycle countdown
    p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwrup_poll_ctr.sv
`timescale 1ns/1ps
// Counts PLL lock samples; last is high on the final allowed sample.
module pwrup_poll_ctr #(
    parameter int unsigned MAX = 4,
    parameter int unsigned W   = $clog2(MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == W'(MAX - 1));

    // R7: the sample count never runs past the allowed number of polls
    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(MAX - 1));

endmodule

// File: rtl/pwrup_seq.sv
`timescale 1ns/1ps
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int unsigned REF_DLY    = 1000,
    parameter int unsigned SETTLE_DLY = 20000,
    parameter int unsigned PERST_DLY  = 10000000,
    parameter int unsigned POLL_GAP   = 5000,
    parameter int unsigned POLL_MAX   = 2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 pwr_down,
    input  logic                 rst_act_high,
    input  logic [NUM_EN-1:0]    step_fail,
    input  logic                 pll_locked,
    output logic                 supply_en,
    output logic [NUM_EN-2:0]    clk_en,
    output logic                 phy_pd,
    output logic                 ref_clk_en,
    output logic                 ep_rst,
    output logic                 phy_rst,
    output logic                 seq_done,
    output logic                 seq_err
);

    localparam int unsigned IW      = $clog2(NUM_EN);
    localparam int unsigned DLY_A   = (REF_DLY > SETTLE_DLY) ? REF_DLY : SETTLE_DLY;
    localparam int unsigned DLY_B   = (PERST_DLY > POLL_GAP) ? PERST_DLY : POLL_GAP;
    localparam int unsigned DLY_MAX = (DLY_A > DLY_B) ? DLY_A : DLY_B;
    localparam int unsigned TW      = $clog2(DLY_MAX + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_EN - 1);

    typedef struct packed {
        seq_state_e          st;
        logic [IW-1:0]       idx;
        logic [NUM_EN-1:0]   en;
        logic                phy_pd;
        logic                ref_en;
        logic                ep_assert;
        logic                phy_rst;
        logic                done;
        logic                err;
    } seq_regs_t;

    localparam seq_regs_t SEQ_REST = '{
        st:        ST_IDLE,
        idx:       '0,
        en:        '0,
        phy_pd:    1'b1,
        ref_en:    1'b0,
        ep_assert: 1'b0,
        phy_rst:   1'b1,
        done:      1'b0,
        err:       1'b0
    };

    seq_regs_t      r_d, r_q;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_expire;
    logic           poll_clr;
    logic           poll_step;
    logic           poll_last;
    logic [IW-1:0]  idx_up;

    assign idx_up = r_q.idx + 1'b1;

    pwrup_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    pwrup_poll_ctr #(.MAX(POLL_MAX)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .step  (poll_step),
        .last  (poll_last)
    );

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        poll_clr  = 1'b0;
        poll_step = 1'b0;
        if (pwr_down) begin
            r_d = SEQ_REST;
        end else begin
            unique case (r_q.st)
                ST_IDLE, ST_FAILED: begin
                    if (start) begin
                        r_d               = SEQ_REST;
                        r_d.st            = ST_ENABLE;
                        r_d.en[EN_SUPPLY] = 1'b1;
                    end
                end
                ST_ENABLE: begin
                    if (step_fail[r_q.idx]) begin
                        r_d.st = ST_UNWIND;
                    end else if (r_q.idx == LAST_IDX) begin
                        r_d.st     = ST_PWRUP;
                        r_d.phy_pd = 1'b0;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(REF_DLY);
                    end else begin
                        r_d.idx        = idx_up;
                        r_d.en[idx_up] = 1'b1;
                    end
                end
                ST_UNWIND: begin
                    r_d.en[r_q.idx] = 1'b0;
                    if (r_q.idx == '0) begin
                        r_d.st  = ST_FAILED;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx - 1'b1;
                    end
                end
                ST_PWRUP: begin
                    if (tmr_expire) begin
                        r_d.st     = ST_SETTLE;
                        r_d.ref_en = 1'b1;
                        tmr_load   = 1'b1;
                        tmr_val    = TW'(SETTLE_DLY);
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expire) begin
                        r_d.st        = ST_EPRST;
                        r_d.ep_assert = 1'b1;
                        tmr_load      = 1'b1;
                        tmr_val       = TW'(PERST_DLY);
                    end
                end
                ST_EPRST: begin
                    if (tmr_expire) begin
                        r_d.st        = ST_LOCK;
                        r_d.ep_assert = 1'b0;
                        r_d.phy_rst   = 1'b0;
                        tmr_load      = 1'b1;
                        tmr_val       = TW'(POLL_GAP);
                        poll_clr      = 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (tmr_expire) begin
                        if (pll_locked) begin
                            r_d.st   = ST_DONE;
                            r_d.done = 1'b1;
                        end else if (poll_last) begin
                            r_d.st  = ST_FAILED;
                            r_d.err = 1'b1;
                        end else begin
                            tmr_load  = 1'b1;
                            tmr_val   = TW'(POLL_GAP);
                            poll_step = 1'b1;
                        end
                    end
                end
                ST_DONE: begin
                    r_d = r_q;
                end
                default: r_d = SEQ_REST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_REST;
        end else begin
            r_q <= r_d;
        end
    end

    assign supply_en  = r_q.en[EN_SUPPLY];
    assign clk_en     = r_q.en[NUM_EN-1:1];
    assign phy_pd     = r_q.phy_pd;
    assign ref_clk_en = r_q.ref_en;
    assign ep_rst     = r_q.ep_assert ? rst_act_high : ~rst_act_high;
    assign phy_rst    = r_q.phy_rst;
    assign seq_done   = r_q.done;
    assign seq_err    = r_q.err;

    // R2: no clock is ever on without the supply
    p_clk_needs_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|clk_en) |-> supply_en);

    // R2: each enable only rises once its predecessor is already on
    for (genvar g = 1; g < NUM_EN; g++) begin : g_order
        p_en_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(r_q.en[g]) |-> r_q.en[g-1]);
    end

    // R3: reference clock only runs with the PHY powered up
    p_ref_after_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_clk_en |-> !phy_pd);

    // R5: the PHY reset is held for as long as the external reset is active
    p_ep_before_phy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ep_assert |-> phy_rst);

    // R6: completion requires that the lock flag was seen
    p_done_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $past(pll_locked));

    // R7: done and error never coexist
    p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err));

    // R8: unwinding drops exactly one enable per cycle
    p_unwind_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_UNWIND && !pwr_down)
        |=> ($countones(r_q.en) + 1 == $past($countones(r_q.en))));

    // R9: power-down request brings the rest state next cycle
    p_pwr_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!supply_en && phy_pd && !ref_clk_en && phy_rst && !seq_done));

endmodule

// File: tb/pwrup_seq_tb.sv
`timescale 1ns/1ps
module pwrup_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REF_DLY    = 5;
    localparam int SETTLE_DLY = 8;
    localparam int PERST_DLY  = 12;
    localparam int POLL_GAP   = 3;
    localparam int POLL_MAX   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       pwr_down = 1'b0;
    logic       rst_act_high = 1'b0;
    logic [3:0] step_fail = '0;
    logic       pll_locked = 1'b0;
    logic       supply_en;
    logic [2:0] clk_en;
    logic       phy_pd;
    logic       ref_clk_en;
    logic       ep_rst;
    logic       phy_rst;
    logic       seq_done;
    logic       seq_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_seq #(
        .REF_DLY(REF_DLY), .SETTLE_DLY(SETTLE_DLY), .PERST_DLY(PERST_DLY),
        .POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pwr_down(pwr_down),
        .rst_act_high(rst_act_high), .step_fail(step_fail), .pll_locked(pll_locked),
        .supply_en(supply_en), .clk_en(clk_en), .phy_pd(phy_pd),
        .ref_clk_en(ref_clk_en), .ep_rst(ep_rst), .phy_rst(phy_rst),
        .seq_done(seq_done), .seq_err(seq_err)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Expected-output model
    logic       m_sup, m_pd, m_ref, m_epa, m_prst, m_done, m_err;
    logic [2:0] m_clk;

    typedef struct {
        logic [9:0] v;
        int         gap;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    function automatic logic [9:0] dut_vec();
        return {supply_en, clk_en, phy_pd, ref_clk_en, ep_rst, phy_rst, seq_done, seq_err};
    endfunction

    function automatic logic [9:0] model_vec();
        logic lvl;
        lvl = m_epa ? rst_act_high : ~rst_act_high;
        return {m_sup, m_clk, m_pd, m_ref, lvl, m_prst, m_done, m_err};
    endfunction

    task automatic model_rest();
        m_sup = 0; m_clk = '0; m_pd = 1; m_ref = 0; m_epa = 0;
        m_prst = 1; m_done = 0; m_err = 0;
    endtask

    task automatic push(input int gap, input string tag);
        exp_t e;
        e.v = model_vec(); e.gap = gap; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic direct_check(input logic [9:0] exp, input string tag);
        n_checks++;
        if (dut_vec() !== exp) begin
            n_errors++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, dut_vec(), exp);
        end
    endtask

    // Monitor: every output change pops one expected item
    bit         mon_en = 1'b0;
    int         cyc = 0;
    int         last_cyc = 0;
    logic [9:0] last_v = '0;

    always @(negedge clk) begin
        logic [9:0] cur;
        exp_t       e;
        cyc++;
        cur = dut_vec();
        if (cur !== last_v) begin
            if (mon_en) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_errors++;
                    $display("FAIL unexpected change (R10): actual=%b expected=%b", cur, last_v);
                end else begin
                    e = exp_q.pop_front();
                    if (cur !== e.v || (e.gap >= 0 && (cyc - last_cyc) != e.gap)) begin
                        n_errors++;
                        $display("FAIL %s: actual=%b gap=%0d expected=%b gap=%0d",
                                 e.tag, cur, cyc - last_cyc, e.v, e.gap);
                    end
                end
            end
            last_cyc = cyc;
        end
        last_v = cur;
    end

    task automatic drain(input int lim, input string tag);
        int k;
        k = 0;
        while (exp_q.size() != 0 && k < lim) begin
            @(negedge clk);
            k++;
        end
        if (exp_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL %s: %0d changes missing, actual=0 expected=%0d",
                     tag, exp_q.size(), exp_q.size());
            exp_q.delete();
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_pwr_down(input string tag);
        model_rest();
        push(-1, tag);
        @(negedge clk); pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        drain(10, tag);
    endtask

    // Expected items from start through release of the PHY reset
    task automatic push_bringup();
        m_sup = 1;       push(-1, "R2 supply");
        m_clk[0] = 1;    push(1, "R2 phy clk");
        m_clk[1] = 1;    push(1, "R2 bus clk");
        m_clk[2] = 1;    push(1, "R2 core clk");
        m_pd = 0;        push(1, "R3 power-up");
        m_ref = 1;       push(REF_DLY, "R3 ref clk");
        m_epa = 1;       push(SETTLE_DLY, "R4 ext reset active");
        m_epa = 0; m_prst = 0; push(PERST_DLY, "R5 ext reset release");
    endtask

    task automatic fail_case(input int k);
        string t;
        t = $sformatf("R8 fail step %0d", k);
        step_fail = 4'b0001 << k;
        m_sup = 1; push(-1, t);
        for (int i = 1; i <= k; i++) begin
            m_clk[i-1] = 1; push(1, t);
        end
        if (k == 0) begin
            m_sup = 0; m_err = 1; push(2, t);
        end else begin
            m_clk[k-1] = 0; push(2, t);
            for (int i = k - 1; i >= 1; i--) begin
                m_clk[i-1] = 0; push(1, t);
            end
            m_sup = 0; m_err = 1; push(1, t);
        end
        pulse_start();
        drain(40, t);
        step_fail = '0;
        do_pwr_down("R9 clear after step fail");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        model_rest();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: rest state with both external reset polarities
        rst_act_high = 1'b0;
        @(negedge clk);
        direct_check(model_vec(), "R1 rest, active-low reset");
        rst_act_high = 1'b1;
        @(negedge clk);
        direct_check(model_vec(), "R1 rest, active-high reset");
        @(negedge clk);
        mon_en = 1'b1;

        // Full sequence, lock already set, stray start during external reset
        pll_locked = 1'b1;
        push_bringup();
        m_done = 1; push(POLL_GAP, "R6 done on first sample");
        pulse_start();
        repeat (4 + REF_DLY + SETTLE_DLY + 3) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;   // R10 mid-sequence
        drain(200, "R6 full sequence");
        pulse_start();                                // R10 after completion
        repeat (10) @(negedge clk);
        direct_check(model_vec(), "R10 start ignored after done");
        do_pwr_down("R9 from done");
        pll_locked = 1'b0;

        // Active-low external reset, lock set late
        mon_en = 1'b0;
        rst_act_high = 1'b0;
        @(negedge clk); @(negedge clk);
        mon_en = 1'b1;
        push_bringup();
        m_done = 1; push(2 * POLL_GAP, "R6 late lock");
        pulse_start();
        while (phy_rst !== 1'b0) @(negedge clk);
        repeat (POLL_GAP + 1) @(negedge clk);
        pll_locked = 1'b1;
        drain(200, "R6 late lock");
        do_pwr_down("R9 after late lock");
        pll_locked = 1'b0;

        // Lock never sets
        push_bringup();
        m_err = 1; push(POLL_GAP * POLL_MAX, "R7 lock timeout");
        pulse_start();
        drain(200, "R7 lock timeout");
        do_pwr_down("R9 after lock timeout");

        // Step failures
        fail_case(0);
        fail_case(2);
        fail_case(3);

        // Power-down while waiting for settling
        m_sup = 1;    push(-1, "R2 supply");
        m_clk[0] = 1; push(1, "R2 phy clk");
        m_clk[1] = 1; push(1, "R2 bus clk");
        m_clk[2] = 1; push(1, "R2 core clk");
        m_pd = 0;     push(1, "R3 power-up");
        m_ref = 1;    push(REF_DLY, "R3 ref clk");
        pulse_start();
        drain(100, "R3 partial");
        do_pwr_down("R9 mid settle");
        repeat (SETTLE_DLY + PERST_DLY) @(negedge clk);
        direct_check(model_vec(), "R9 stays at rest");

        mon_en = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule